// File: doc/BRIEF.md
# Binary Time-Base Timer with Periodic Interrupts

This block divides a 32.768 kHz source rate down through a binary chain and exposes the eight slowest stages (128 Hz down to 1 Hz) as live, readable bits. Software sees them as two 4-bit nibbles on a small register bus. The source rate arrives as a one-cycle enable pulse, `src_tick`, in the system clock domain. The divider advances by one on each such pulse.

Three stages of the chain raise periodic interrupt events: 32 Hz, 8 Hz and 2 Hz. An event is taken when its stage falls from 1 to 0. Each event sets a sticky factor flag, whether or not its mask allows a request. Reading the flag register returns the flags and clears them. The interrupt output is high while any flag is set with its mask enabled.

A single run bit controls the chain. Setting it lets the divider count. Clearing it zeroes the divider and holds it there.

Top module: `clock_timer`

## Requirements
- R1: Reading address 0 returns the 128 Hz, 64 Hz, 32 Hz and 16 Hz stages on data bits 0, 1, 2 and 3. These are divider count bits 7 to 10.
- R2: Reading address 1 returns the 8 Hz, 4 Hz, 2 Hz and 1 Hz stages on data bits 0, 1, 2 and 3. These are divider count bits 11 to 14.
- R3: After reset, every address reads 0 and `irq` is low. This covers both stage nibbles, the masks, the run bit and the flags.
- R4: A 1-to-0 change of a stage sets its factor flag at address 3. The 32 Hz stage sets bit 0, the 8 Hz stage sets bit 1 and the 2 Hz stage sets bit 2. The flag becomes visible in the cycle in which the stage reads 0.
- R5: A read of address 3 returns the current flags. It clears them at the clock edge that ends the read cycle.
- R6: An event that lands on the same edge as a clearing read of address 3 leaves its flag set.
- R7: Address 2 holds the interrupt masks on bits 0 to 2, with 1 meaning enabled, in the same bit order as the flags. A flag sets even when its mask is 0. `irq` is high exactly while some flag and its mask bit are both 1.
- R8: Address 2 bit 3 is the run bit. With it at 1 the divider counts. Writing 0 zeroes the divider from the following cycle and holds it at 0. No events occur while stopped, and a later run restarts counting from zero.
- R9: While running, the divider advances only in cycles where `src_tick` is high.
- R10: Writes to addresses 0, 1 and 3 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 1 | One pulse per period of the 32.768 kHz source |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of address 3 clears the flags |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, valid while bus_rd is high, 0 otherwise |
| irq | output | 1 | Interrupt request |

## Verification
The divider is read at counts chosen so that both nibbles take distinct, non-trivial patterns. This separates errors in tap order from errors in nibble placement.

Flags are read just after the first 32 Hz fall, just after the combined 32 Hz and 8 Hz fall, and after the 2 Hz fall. Each of these expects a different bit set, which exposes swapped or missing sources. A read placed on the exact cycle of an event distinguishes set-wins from clear-wins. Running with the mask cleared, and then set, shows whether the mask gates only the request or also the flag.

A pause of `src_tick`, a stop, and a restart check that counting follows the enable and that stopping zeroes the chain.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
    localparam int NIBBLE = 4;
    localparam int ADDR_W = 2;
    localparam int IRQ_N  = 3;
    localparam int DIV_W  = 15;
    localparam int NTAP   = 2 * NIBBLE;

    localparam logic [ADDR_W-1:0] A_TAP_LO = 2'd0;
    localparam logic [ADDR_W-1:0] A_TAP_HI = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
    localparam logic [ADDR_W-1:0] A_FLAG   = 2'd3;

    // Tap index (within the readable taps) that feeds interrupt source i:
    // 0 -> 32 Hz, 1 -> 8 Hz, 2 -> 2 Hz
    function automatic int irq_tap(input int i);
        return 2 + 2 * i;
    endfunction
endpackage

// File: rtl/ctmr_divider.sv
module ctmr_divider #(
    parameter int DIV_W = ctmr_pkg::DIV_W,
    parameter int NTAP  = ctmr_pkg::NTAP,
    parameter int N     = ctmr_pkg::IRQ_N
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            src_tick,
    output logic [NTAP-1:0] taps,
    output logic [N-1:0]    fall_ev
);
    localparam int LOW = DIV_W - NTAP;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (!run) begin
            div_d.cnt = '0;
        end else if (src_tick) begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign taps = div_q.cnt[DIV_W-1 -: NTAP];

    // A tap falls on the increment that carries out of all bits at and below it
    for (genvar i = 0; i < N; i++) begin : g_fall
        localparam int POS = LOW + ctmr_pkg::irq_tap(i);
        assign fall_ev[i] = run && src_tick && (&div_q.cnt[POS:0]);
    end
endmodule

// File: rtl/ctmr_irq.sv
module ctmr_irq #(
    parameter int N = ctmr_pkg::IRQ_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fall_ev,
    input  logic         rd_clr,
    input  logic         mask_we,
    input  logic [N-1:0] mask_in,
    output logic [N-1:0] flags,
    output logic [N-1:0] mask,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] flag;
        logic [N-1:0] mask;
    } irq_state_t;

    irq_state_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (rd_clr) begin
            irq_d.flag = '0;
        end
        // set has priority over the clear so no event is lost
        irq_d.flag = irq_d.flag | fall_ev;
        if (mask_we) begin
            irq_d.mask = mask_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign flags = irq_q.flag;
    assign mask  = irq_q.mask;
    assign irq   = |(irq_q.flag & irq_q.mask);
endmodule

// File: rtl/clock_timer.sv
module clock_timer
    import ctmr_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NIBBLE-1:0] bus_wdata,
    output logic [NIBBLE-1:0] bus_rdata,
    output logic              irq
);
    typedef struct packed {
        logic run;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [NTAP-1:0]  tap_vec;
    logic [IRQ_N-1:0] ev_vec;
    logic [IRQ_N-1:0] flag_vec;
    logic [IRQ_N-1:0] mask_vec;
    logic             ctrl_we;
    logic             rd_clr;

    assign ctrl_we = bus_wr && (bus_addr == A_CTRL);
    assign rd_clr  = bus_rd && (bus_addr == A_FLAG);

    always_comb begin
        top_d = top_q;
        if (ctrl_we) begin
            top_d.run = bus_wdata[NIBBLE-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    ctmr_divider #(
        .DIV_W(DW),
        .NTAP (NTAP),
        .N    (IRQ_N)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (top_q.run),
        .src_tick(src_tick),
        .taps    (tap_vec),
        .fall_ev (ev_vec)
    );

    ctmr_irq #(
        .N(IRQ_N)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_ev(ev_vec),
        .rd_clr (rd_clr),
        .mask_we(ctrl_we),
        .mask_in(bus_wdata[IRQ_N-1:0]),
        .flags  (flag_vec),
        .mask   (mask_vec),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_TAP_LO: bus_rdata = tap_vec[NIBBLE-1:0];
                A_TAP_HI: bus_rdata = tap_vec[NTAP-1:NIBBLE];
                A_CTRL:   bus_rdata = {top_q.run, mask_vec};
                default:  bus_rdata = {{(NIBBLE-IRQ_N){1'b0}}, flag_vec};
            endcase
        end
    end
endmodule

// File: rtl/clock_timer_chk.sv
module clock_timer_chk #(
    parameter int NT = 8,
    parameter int N  = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          src_tick,
    input logic          run,
    input logic [NT-1:0] taps,
    input logic [N-1:0]  ev,
    input logic [N-1:0]  flags,
    input logic [N-1:0]  mask,
    input logic          rd_clr,
    input logic          irq
);
    assert_stop_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (taps == '0));

    assert_no_event_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (ev == '0));

    assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !src_tick) |=> $stable(taps));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (ev == '0)) |=> (flags == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));

    assert_flag_from_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags)) != '0) |-> ($past(ev) != '0));

    assert_irq_needs_enabled_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags & mask) != '0));
endmodule

bind clock_timer clock_timer_chk #(
    .NT(ctmr_pkg::NTAP),
    .N (ctmr_pkg::IRQ_N)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_tick(src_tick),
    .run     (top_q.run),
    .taps    (tap_vec),
    .ev      (ev_vec),
    .flags   (flag_vec),
    .mask    (mask_vec),
    .rd_clr  (rd_clr),
    .irq     (irq)
);

// File: tb/clock_timer_tb.sv
`timescale 1ns/1ps
module clock_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_tick = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       irq;

    int total = 0;
    int bad = 0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    // reference count: source pulses seen while the run bit is set
    logic        m_run = 1'b0;
    logic [14:0] mcnt = '0;

    always #2 clk = ~clk;

    clock_timer u_dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run <= 1'b0;
            mcnt  <= '0;
        end else begin
            if (bus_wr && bus_addr == 2'd2) m_run <= bus_wdata[3];
            if (!m_run) mcnt <= '0;
            else if (src_tick) mcnt <= mcnt + 1'b1;
        end
    end

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected item for each read cycle
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL scoreboard: actual=%h expected=none", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [3:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        step();
        bus_rd = 1'b0;
    endtask

    task automatic wait_cnt(input int target);
        while (int'(mcnt) != target) step();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [14:0] held;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R3 reset state
        rd(2'd0, 4'h0, "R3 low taps");
        rd(2'd1, 4'h0, "R3 high taps");
        rd(2'd2, 4'h0, "R3 ctrl");
        rd(2'd3, 4'h0, "R3 flags");
        check({3'b0, irq}, 4'h0, "R3 irq");

        // R10 writes to read-only addresses
        wr(2'd0, 4'hF);
        wr(2'd1, 4'hF);
        wr(2'd3, 4'h7);
        rd(2'd0, 4'h0, "R10 low taps");
        rd(2'd1, 4'h0, "R10 high taps");
        rd(2'd3, 4'h0, "R10 flags");
        rd(2'd2, 4'h0, "R10 ctrl");

        // R8 run, masks off
        wr(2'd2, 4'h8);
        wait_cnt(200);
        rd(2'd0, 4'h1, "R1 count 200");
        wait_cnt(1000);
        rd(2'd0, 4'h7, "R1 count 1000");

        // R4/R7 flag set while masked
        wait_cnt(1030);
        check({3'b0, irq}, 4'h0, "R7 masked irq");
        rd(2'd3, 4'h1, "R4 32Hz flag");
        rd(2'd3, 4'h0, "R5 cleared");

        wr(2'd2, 4'h9);
        rd(2'd2, 4'h9, "R7 ctrl readback");
        wait_cnt(2060);
        check({3'b0, irq}, 4'h1, "R7 enabled irq");
        rd(2'd3, 4'h1, "R4 32Hz flag again");
        check({3'b0, irq}, 4'h0, "R5 irq after clear");

        // R6 collision of read and event
        wait_cnt(3071);
        rd(2'd3, 4'h0, "R6 read on event cycle");
        rd(2'd3, 4'h1, "R6 flag kept");

        wait_cnt(4100);
        rd(2'd3, 4'h3, "R4 32Hz and 8Hz");

        wait_cnt(20000);
        rd(2'd1, 4'h9, "R2 high nibble");
        wait_cnt(20001);
        rd(2'd0, 4'hC, "R1 low nibble");
        rd(2'd3, 4'h7, "R4 all three");

        // R9 pause
        src_tick = 1'b0;
        held = mcnt;
        repeat (100) step();
        rd(2'd0, 4'((held >> 7) & 15), "R9 low hold");
        rd(2'd1, 4'((held >> 11) & 15), "R9 high hold");
        src_tick = 1'b1;

        // R8 stop
        wr(2'd2, 4'h0);
        step();
        rd(2'd0, 4'h0, "R8 low after stop");
        rd(2'd1, 4'h0, "R8 high after stop");
        repeat (2000) step();
        rd(2'd3, 4'h0, "R8 no events stopped");
        rd(2'd0, 4'h0, "R8 held zero");
        check({3'b0, irq}, 4'h0, "R8 irq stopped");

        // R8 restart from zero
        wr(2'd2, 4'h8);
        wait_cnt(128);
        rd(2'd0, 4'h1, "R8 restart");

        step();
        finish_run();
    end
endmodule